// File: doc/BRIEF.md
# Subpixel Dither Colour Encoder

This block turns a 15-bit colour word (5 bits each for red, green and blue) into a video output that carries only 2 bits per component. It shows in-between shades by moving each component between two neighbouring 2-bit levels across a run of subpixel slots. Averaged over one pixel, each component's level follows the requested shade. Only 25 shades per component can be told apart, so the three components together give 15625 colours. Any input code above the top usable shade is held at that top shade.

A pixel lasts a fixed number of subpixel slots. The default is 8 slots, counted by an internal 3-bit phase counter. The video timing logic pulses `pix_stb` in the first slot of each pixel and holds the colour word steady until the next pulse. A 5-bit shade `v` splits into a coarse level `v >> 3` and a remainder `v & 7`. The coarse level is raised by one in as many slots as the remainder says. The raised slots are picked through a bit-reversed phase, which spreads them evenly across the pixel. A parameter can pick plain ascending order instead.

Top module: `dith_encoder`

## Requirements
- R1: The colour word is split as red = `rgb_in[14:10]`, green = `rgb_in[9:5]`, blue = `rgb_in[4:0]`. Each one drives its own 2-bit output (`r_lvl`, `g_lvl`, `b_lvl`). The outputs are registered, so an output shows the result for the input and phase of the previous clock cycle.
- R2: Let `c` be the clamped code (`min(v,24)`). Every slot's output for that component is either `c>>3` or `(c>>3)+1`.
- R3: Input codes 25 to 31 give exactly the same output as code 24, which is a constant level 3 in every slot.
- R4: Code 0 gives a constant level 0 in every slot.
- R5: Over the 8 slots of one pixel, a component's levels add up to its clamped code. This holds for all 32 input codes.
- R6: The slot phase is 0 in the cycle where `pix_stb` is high. It then rises by one each cycle and wraps after 7. In phase `p`, the output is `(c>>3)+1` exactly when `(c & 7)` is greater than the 3-bit reversal of `p`.
- R7: While the synchronous reset `rst` is high, all outputs go to 0 at the next edge and the phase goes back to 0.
- R8: A `pix_stb` pulse in the middle of a pixel sets the phase back to 0 in that same cycle. The pattern then starts over from slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subpixel slot clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | High in the first slot of each pixel |
| rgb_in | input | 15 | Red, green and blue shade codes, 5 bits each |
| r_lvl | output | 2 | Registered red output level |
| g_lvl | output | 2 | Registered green output level |
| b_lvl | output | 2 | Registered blue output level |

## Verification
The bench builds the encoder with its default parameters: 5-bit components, 2-bit outputs, a 3-bit phase and bit-reversed slot order. With a 5-bit component, one sweep reaches every input code, so all seven clamped codes and both constant ends are covered, along with every remainder from 0 to 7. The bench checks each slot against the bit-reversed pattern and adds up every pixel to check the average. It also places a strobe mid-pixel to check the early restart.

// File: rtl/dith_pkg.sv
package dith_pkg;

   // slot order variants
   localparam int ORDER_BITREV = 0;
   localparam int ORDER_LINEAR = 1;

   // reverse the low n bits of x
   function automatic logic [7:0] rev_low(input logic [7:0] x, input int n);
      logic [7:0] y;
      y = '0;
      for (int i = 0; i < 8; i++) begin
         if (i < n) y[i] = x[n-1-i];
      end
      return y;
   endfunction

endpackage

// File: rtl/dith_phase_ctr.sv
module dith_phase_ctr #(
   parameter int PH_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pix_stb,
   output logic [PH_W-1:0] ph_cur
);

   logic [PH_W-1:0] ph_q;

   // the strobe slot itself is phase zero
   assign ph_cur = pix_stb ? '0 : ph_q;

   always_ff @(posedge clk) begin
      if (rst) ph_q <= '0;
      else     ph_q <= ph_cur + PH_W'(1);
   end

   // R8: the slot after a strobe is phase one unless it strobes again
   p_restart_r8: assert property (@(posedge clk) disable iff (rst)
      pix_stb |=> (pix_stb || ph_cur == PH_W'(1)));

   // R6: phase advances by one between strobes
   p_step_r6: assert property (@(posedge clk) disable iff (rst)
      !pix_stb |=> (pix_stb || ph_cur == $past(ph_cur) + PH_W'(1)));

   // R7: reset returns phase to zero
   p_rst_phase_r7: assert property (@(posedge clk)
      rst |=> (ph_cur == '0));

endmodule

// File: rtl/dith_comp.sv
module dith_comp
   import dith_pkg::*;
#(
   parameter int COMP_W = 5,
   parameter int OUT_W  = 2,
   parameter int PH_W   = 3,
   parameter int ORDER  = ORDER_BITREV
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [COMP_W-1:0] code,
   input  logic [PH_W-1:0]   ph,
   output logic [OUT_W-1:0]  lvl
);

   localparam int LVL_MAX  = (1 << OUT_W) - 1;
   localparam int SAT_CODE = LVL_MAX << PH_W;
   localparam int Q_W      = COMP_W - PH_W;

   logic [COMP_W-1:0] clamped;
   logic [Q_W-1:0]    coarse;
   logic [PH_W-1:0]   frac;
   logic [PH_W-1:0]   key;
   logic              bump;
   logic [OUT_W-1:0]  lvl_q;

   assign clamped = (int'(code) > SAT_CODE) ? COMP_W'(SAT_CODE) : code;
   assign coarse  = clamped[COMP_W-1:PH_W];
   assign frac    = clamped[PH_W-1:0];

   generate
      if (ORDER == ORDER_BITREV) begin : g_rev
         logic [7:0] rev8;
         assign rev8 = rev_low(8'(ph), PH_W);
         assign key  = rev8[PH_W-1:0];
      end else begin : g_lin
         assign key = ph;
      end
   endgenerate

   assign bump = (frac > key);

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= OUT_W'(coarse) + OUT_W'(bump);
   end

   assign lvl = lvl_q;

   // R2: output stays within one step above the coarse level
   p_band_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (int'(lvl) == (int'($past(clamped)) >> PH_W) ||
                int'(lvl) == (int'($past(clamped)) >> PH_W) + 1));

   // R3: codes at or above saturation give full level
   p_sat_r3: assert property (@(posedge clk) disable iff (rst)
      (int'(code) >= SAT_CODE) |=> (int'(lvl) == LVL_MAX));

   // R4: code zero gives level zero
   p_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (code == '0) |=> (lvl == '0));

   // R7: reset clears the output
   p_rst_lvl_r7: assert property (@(posedge clk)
      rst |=> (lvl == '0));

endmodule

// File: rtl/dith_encoder.sv
module dith_encoder
   import dith_pkg::*;
#(
   parameter int COMP_W = 5,
   parameter int OUT_W  = 2,
   parameter int PH_W   = 3,
   parameter int ORDER  = ORDER_BITREV
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pix_stb,
   input  logic [3*COMP_W-1:0] rgb_in,
   output logic [OUT_W-1:0]    r_lvl,
   output logic [OUT_W-1:0]    g_lvl,
   output logic [OUT_W-1:0]    b_lvl
);

   localparam int N_COMP   = 3;
   localparam int SAT_CODE = ((1 << OUT_W) - 1) << PH_W;

   generate
      if (PH_W < 1 || PH_W > 8) begin : g_bad_ph
         $error("PH_W must lie in 1..8");
      end
      if (COMP_W <= PH_W) begin : g_bad_w
         $error("COMP_W must exceed PH_W");
      end
      if (SAT_CODE > (1 << COMP_W) - 1) begin : g_bad_sat
         $error("saturation code does not fit COMP_W");
      end
      if (ORDER != ORDER_BITREV && ORDER != ORDER_LINEAR) begin : g_bad_ord
         $error("unknown ORDER");
      end
   endgenerate

   logic [PH_W-1:0]  ph;
   logic [OUT_W-1:0] lvl [N_COMP];

   dith_phase_ctr #(.PH_W(PH_W)) u_ph (
      .clk(clk), .rst(rst), .pix_stb(pix_stb), .ph_cur(ph)
   );

   // index 0 blue, 1 green, 2 red
   generate
      for (genvar c = 0; c < N_COMP; c++) begin : g_comp
         dith_comp #(
            .COMP_W(COMP_W), .OUT_W(OUT_W), .PH_W(PH_W), .ORDER(ORDER)
         ) u_comp (
            .clk(clk), .rst(rst),
            .code(rgb_in[c*COMP_W +: COMP_W]),
            .ph(ph), .lvl(lvl[c])
         );
      end
   endgenerate

   assign b_lvl = lvl[0];
   assign g_lvl = lvl[1];
   assign r_lvl = lvl[2];

endmodule

// File: tb/sim_dith_encoder.sv
`timescale 1ns/1ps
module sim_dith_encoder;

   typedef struct {
      logic [5:0] exp;       // {r,g,b} 2 bits each
      int         req;       // requirement tag number for messages
      bit         first;     // first slot of a pixel
      bit         last;      // last slot of a pixel
      int         sum_r;     // expected clamped red code
   } item_t;

   logic        clk = 0;
   logic        rst = 1;
   logic        pix_stb = 0;
   logic [14:0] rgb_in = '0;
   logic [1:0]  r_lvl, g_lvl, b_lvl;

   int checks = 0;
   int fails  = 0;
   int ph_b   = 0;
   int acc_r  = 0;
   item_t q[$];
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   dith_encoder u0 (
      .clk(clk), .rst(rst), .pix_stb(pix_stb), .rgb_in(rgb_in),
      .r_lvl(r_lvl), .g_lvl(g_lvl), .b_lvl(b_lvl)
   );

   function automatic int clampc(int v);
      return (v > 24) ? 24 : v;
   endfunction

   function automatic int rev3(int p);
      return ((p & 1) << 2) | (p & 2) | ((p >> 2) & 1);
   endfunction

   // R6: level for clamped code c in phase p
   function automatic int lvl_of(int v, int p);
      int c;
      c = clampc(v);
      return (c >> 3) + (((c & 7) > rev3(p)) ? 1 : 0);
   endfunction

   // one slot of stimulus; pushes the expected result
   task automatic drive(bit r_, bit stb, int rv, int gv, int bv, int req,
                        bit last);
      item_t it;
      int p;
      @(negedge clk);
      rst     = r_;
      pix_stb = stb;
      rgb_in  = {5'(rv), 5'(gv), 5'(bv)};
      if (r_) begin
         it.exp = '0;
         ph_b   = 0;
         p      = 0;
      end else begin
         p = stb ? 0 : ph_b;
         it.exp = {2'(lvl_of(rv, p)), 2'(lvl_of(gv, p)), 2'(lvl_of(bv, p))};
         ph_b = (p + 1) % 8;
      end
      it.req   = req;
      it.first = !r_ && stb;
      it.last  = last;
      it.sum_r = clampc(rv);
      q.push_back(it);
   endtask

   // monitor: compares after each edge
   always @(posedge clk) begin
      item_t it;
      #2;
      if (q.size() > 0) begin
         it = q.pop_front();
         checks++;
         if ({r_lvl, g_lvl, b_lvl} !== it.exp) begin
            fails++;
            $display("FAIL R%0d slot: actual %b expected %b",
                     it.req, {r_lvl, g_lvl, b_lvl}, it.exp);
         end
         if (it.first) acc_r = 0;
         acc_r += int'(r_lvl);
         if (it.last) begin
            checks++;  // R5 pixel sum
            if (acc_r != it.sum_r) begin
               fails++;
               $display("FAIL R5 pixel sum: actual %0d expected %0d",
                        acc_r, it.sum_r);
            end
         end
      end
   end

   initial begin
      // R7: reset state
      drive(1, 0, 0, 0, 0, 7, 0);
      drive(1, 0, 31, 31, 31, 7, 0);
      // R1/R2/R3/R4/R6: sweep every red code, other components vary
      for (int c = 0; c < 32; c++) begin
         int tag;
         tag = (c == 0) ? 4 : (c >= 24) ? 3 : 6;
         for (int s = 0; s < 8; s++)
            drive(0, s == 0, c, 31 - c, (c * 7) % 32, tag, s == 7);
      end
      // R1: component independence, distinct codes per field
      for (int s = 0; s < 8; s++) drive(0, s == 0, 5, 13, 27, 1, s == 7);
      // R8: strobe after three slots restarts the pattern
      for (int s = 0; s < 3; s++) drive(0, s == 0, 3, 7, 11, 8, 0);
      for (int s = 0; s < 8; s++) drive(0, s == 0, 19, 2, 9, 8, s == 7);
      // R7: reset mid-pixel, then a full pixel
      drive(0, 1, 21, 21, 21, 7, 0);
      drive(0, 0, 21, 21, 21, 7, 0);
      drive(1, 0, 21, 21, 21, 7, 0);
      for (int s = 0; s < 8; s++) drive(0, s == 0, 21, 26, 1, 7, s == 7);
      drive(0, 0, 0, 0, 0, 1, 0);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  checks, fails);
         $finish;
      end
   end

endmodule